// File: doc/BRIEF.md
# Extended-Precision Floating-Point Comparator

This block compares two 80-bit extended-precision floating-point values, A and B, and reports the relation between them on three flag outputs. The flags are named after the usual zero, parity and carry status flags. The block also reports whether the compare raised the invalid-operand exception.

A compare starts with a one-cycle `start` pulse that carries both operands, the mode and the mask. The registered result appears on the next cycle together with a `done` strobe. The flag registers hold their value between compares. A compare that raises an unmasked exception leaves them unchanged. Two controls shape the exception policy:
- The mode input picks a signaling compare, in which every NaN is invalid, or a quiet compare, in which only a signaling NaN or a malformed encoding is invalid.
- The mask input decides whether an invalid compare still writes the unordered flags.

The overflow flag is cleared by every compare. For stack-popping compare forms, a pop request is passed through to the surrounding stack logic with the result.

Top module: `fcmp_unit`

## Requirements
- R1: Operand layout is bit 79 sign, bits 78:64 biased exponent, bit 63 explicit integer bit, bits 62:0 fraction. For ordered operands {zf,pf,cf} becomes 000 when A > B, 001 when A < B and 100 when A = B.
- R2: Positive zero and negative zero compare as equal, giving flags 100 in either order.
- R3: With mixed signs the positive operand is greater. With both operands negative the larger magnitude is the smaller value.
- R4: A NaN has exponent all ones, integer bit 1 and a nonzero fraction. It is quiet when bit 62 is 1 and signaling when bit 62 is 0. With `quiet_mode`=0, any NaN operand sets `inv_exc`.
- R5: With `quiet_mode`=1, a quiet NaN gives flags 111 with `inv_exc`=0 whatever the mask. A signaling NaN sets `inv_exc`.
- R6: An operand with a nonzero exponent and integer bit 0 is malformed. It sets `inv_exc` in both modes and counts as unordered.
- R7: When `inv_exc` is raised, the flags become 111 if `inv_mask`=1. If `inv_mask`=0 they keep their previous values.
- R8: `of_flag` is 0 after every compare, whether or not an exception was raised.
- R9: `done` is high exactly in the cycle after a `start` cycle. `inv_exc` and `pop_out` are high only together with `done`.
- R10: `pop_out` is high with the result when `pop_req` was high with `start`.
- R11: After reset, `done`, `inv_exc`, `pop_out`, `of_flag`, `zf`, `pf` and `cf` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a compare this cycle |
| quiet_mode | input | 1 | 1 = quiet compare, 0 = signaling compare |
| inv_mask | input | 1 | 1 = invalid exception masked, flags still written |
| pop_req | input | 1 | Compare is a popping variant |
| a_in | input | 80 | Operand A |
| b_in | input | 80 | Operand B |
| done | output | 1 | Result valid strobe |
| zf | output | 1 | Equal / unordered flag |
| pf | output | 1 | Unordered flag |
| cf | output | 1 | Less-than / unordered flag |
| of_flag | output | 1 | Overflow flag, cleared by each compare |
| inv_exc | output | 1 | Invalid-operand exception for this result |
| pop_out | output | 1 | Pop request for this result |

## Verification
Every result is due one clock after the `start` cycle: `done`, `inv_exc`, `pop_out`, `of_flag` and the flag registers all change at the first rising edge after `start` is sampled. The driver changes inputs on falling edges and queues the expected item at the same moment it raises `start`. The monitor samples on each falling edge and pops one item whenever `done` is high, so each comparison happens half a cycle after the result edge. Any `done` that arrives with no queued item, and any item still left in the queue at the end, is reported as a failure.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    localparam int EXP_W_DEF = 15;
    localparam int SIG_W_DEF = 64;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_FIN,
        CLS_INF,
        CLS_QNAN,
        CLS_SNAN,
        CLS_BAD
    } cls_e;

    typedef enum logic [1:0] {
        REL_GT,
        REL_LT,
        REL_EQ
    } rel_e;

    typedef struct packed {
        logic zf;
        logic pf;
        logic cf;
    } flags_t;

    localparam flags_t FLAGS_UNORD = '{zf: 1'b1, pf: 1'b1, cf: 1'b1};

    function automatic flags_t flags_of_rel(rel_e r);
        flags_t f;
        f = '{zf: 1'b0, pf: 1'b0, cf: 1'b0};
        case (r)
            REL_LT:  f.cf = 1'b1;
            REL_EQ:  f.zf = 1'b1;
            default: f = '{zf: 1'b0, pf: 1'b0, cf: 1'b0};
        endcase
        return f;
    endfunction

    function automatic logic is_nan(cls_e c);
        return (c == CLS_QNAN) || (c == CLS_SNAN);
    endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W = EXP_W_DEF,
    parameter int SIG_W = SIG_W_DEF
) (
    input  logic [EXP_W+SIG_W-1:0] mag,
    output cls_e                   cls
);
    logic [EXP_W-1:0] exp_f;
    logic             int_bit;
    logic             quiet_bit;
    logic [SIG_W-2:0] frac;

    assign exp_f     = mag[EXP_W+SIG_W-1:SIG_W];
    assign int_bit   = mag[SIG_W-1];
    assign frac      = mag[SIG_W-2:0];
    assign quiet_bit = mag[SIG_W-2];

    always_comb begin
        if (exp_f == '0) begin
            cls = ((frac == '0) && !int_bit) ? CLS_ZERO : CLS_FIN;
        end else if (!int_bit) begin
            cls = CLS_BAD;
        end else if (exp_f == '1) begin
            if (frac == '0)     cls = CLS_INF;
            else if (quiet_bit) cls = CLS_QNAN;
            else                cls = CLS_SNAN;
        end else begin
            cls = CLS_FIN;
        end
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
#(
    parameter int EXP_W = EXP_W_DEF,
    parameter int SIG_W = SIG_W_DEF
) (
    input  logic [EXP_W+SIG_W:0] op_a,
    input  logic [EXP_W+SIG_W:0] op_b,
    output rel_e                 rel
);
    localparam int MAG_W = EXP_W + SIG_W;

    logic             sa, sb;
    logic [MAG_W-1:0] ka, kb;
    logic             mag_gt, mag_lt;

    assign sa     = op_a[MAG_W];
    assign sb     = op_b[MAG_W];
    assign ka     = op_a[MAG_W-1:0];
    assign kb     = op_b[MAG_W-1:0];
    assign mag_gt = ka > kb;
    assign mag_lt = ka < kb;

    always_comb begin
        if ((ka == '0) && (kb == '0)) begin
            rel = REL_EQ;
        end else if (sa != sb) begin
            rel = sa ? REL_LT : REL_GT;
        end else if (mag_gt) begin
            rel = sa ? REL_LT : REL_GT;
        end else if (mag_lt) begin
            rel = sa ? REL_GT : REL_LT;
        end else begin
            rel = REL_EQ;
        end
    end
endmodule

// File: rtl/fcmp_policy.sv
module fcmp_policy
    import fcmp_pkg::*;
(
    input  cls_e cls_a,
    input  cls_e cls_b,
    input  logic quiet_mode,
    output logic unord,
    output logic inv
);
    logic any_bad, any_snan, any_qnan;

    assign any_bad  = (cls_a == CLS_BAD)  || (cls_b == CLS_BAD);
    assign any_snan = (cls_a == CLS_SNAN) || (cls_b == CLS_SNAN);
    assign any_qnan = (cls_a == CLS_QNAN) || (cls_b == CLS_QNAN);

    assign unord = any_bad || is_nan(cls_a) || is_nan(cls_b);
    assign inv   = any_bad || any_snan || (!quiet_mode && any_qnan);
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
    import fcmp_pkg::*;
#(
    parameter int EXP_W = EXP_W_DEF,
    parameter int SIG_W = SIG_W_DEF,
    localparam int OP_W = EXP_W + SIG_W + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            quiet_mode,
    input  logic            inv_mask,
    input  logic            pop_req,
    input  logic [OP_W-1:0] a_in,
    input  logic [OP_W-1:0] b_in,
    output logic            done,
    output logic            zf,
    output logic            pf,
    output logic            cf,
    output logic            of_flag,
    output logic            inv_exc,
    output logic            pop_out
);
    logic [OP_W-1:0] ops [2];
    cls_e            cls [2];
    rel_e            rel;
    logic            unord, inv;
    flags_t          nxt_flags, flags_q;
    logic            write_en;

    assign ops[0] = a_in;
    assign ops[1] = b_in;

    for (genvar gi = 0; gi < 2; gi++) begin : g_cls
        fcmp_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_cls (
            .mag (ops[gi][OP_W-2:0]),
            .cls (cls[gi])
        );
    end

    fcmp_order #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_order (
        .op_a (a_in),
        .op_b (b_in),
        .rel  (rel)
    );

    fcmp_policy u_policy (
        .cls_a      (cls[0]),
        .cls_b      (cls[1]),
        .quiet_mode (quiet_mode),
        .unord      (unord),
        .inv        (inv)
    );

    assign nxt_flags = unord ? FLAGS_UNORD : flags_of_rel(rel);
    assign write_en  = !(inv && !inv_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            done    <= 1'b0;
            inv_exc <= 1'b0;
            pop_out <= 1'b0;
            of_flag <= 1'b0;
            flags_q <= '0;
        end else begin
            done    <= start;
            inv_exc <= start && inv;
            pop_out <= start && pop_req;
            if (start) of_flag <= 1'b0;
            if (start && write_en) flags_q <= nxt_flags;
        end
    end

    assign zf = flags_q.zf;
    assign pf = flags_q.pf;
    assign cf = flags_q.cf;

    p_done_after_start_r9: assert property (@(posedge clk) disable iff (rst)
        start |=> done);
    p_done_only_after_start_r9: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);
    p_exc_with_done_r9: assert property (@(posedge clk) disable iff (rst)
        inv_exc |-> done);
    p_pop_with_done_r10: assert property (@(posedge clk) disable iff (rst)
        pop_out |-> done);
    p_of_cleared_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !of_flag);
    p_masked_unord_r7: assert property (@(posedge clk) disable iff (rst)
        (done && inv_exc && $past(inv_mask)) |-> (zf && pf && cf));
    p_unmasked_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (done && inv_exc && !$past(inv_mask)) |-> $stable({zf, pf, cf}));
    p_parity_means_unord_r1: assert property (@(posedge clk) disable iff (rst)
        (done && pf) |-> (zf && cf));
    p_no_lt_and_eq_r1: assert property (@(posedge clk) disable iff (rst)
        (done && !pf) |-> !(zf && cf));
endmodule

// File: tb/fcmp_unit_bench.sv
module fcmp_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, quiet_mode = 1'b0, inv_mask = 1'b1, pop_req = 1'b0;
    logic [79:0] a_in = '0, b_in = '0;
    logic        done, zf, pf, cf, of_flag, inv_exc, pop_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [2:0] fl;
        logic       inv;
        logic       pop;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    fcmp_unit u_fcmp_unit (
        .clk(clk), .rst(rst), .start(start), .quiet_mode(quiet_mode),
        .inv_mask(inv_mask), .pop_req(pop_req), .a_in(a_in), .b_in(b_in),
        .done(done), .zf(zf), .pf(pf), .cf(cf), .of_flag(of_flag),
        .inv_exc(inv_exc), .pop_out(pop_out)
    );

    function automatic logic [79:0] mk(logic s, logic [14:0] e, logic [63:0] m);
        return {s, e, m};
    endfunction

    localparam logic [63:0] ONE_M = 64'h8000_0000_0000_0000;
    logic [79:0] P1, P2, N1, N2, PZ, NZ, QN, SN, PINF, UN, DN;
    initial begin
        P1   = mk(1'b0, 15'h3FFF, ONE_M);
        P2   = mk(1'b0, 15'h4000, ONE_M);
        N1   = mk(1'b1, 15'h3FFF, ONE_M);
        N2   = mk(1'b1, 15'h4000, ONE_M);
        PZ   = mk(1'b0, 15'h0000, 64'h0);
        NZ   = mk(1'b1, 15'h0000, 64'h0);
        QN   = mk(1'b0, 15'h7FFF, 64'hC000_0000_0000_0000);
        SN   = mk(1'b0, 15'h7FFF, 64'h8000_0000_0000_0001);
        PINF = mk(1'b0, 15'h7FFF, ONE_M);
        UN   = mk(1'b0, 15'h3FFF, 64'h4000_0000_0000_0000);
        DN   = mk(1'b0, 15'h0000, 64'h0000_0000_0000_0001);
    end

    task automatic check(string tag, logic [7:0] act, logic [7:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, expv);
        end
    endtask

    task automatic do_cmp(logic [79:0] a, logic [79:0] b, logic q, logic m,
                          logic p, logic [2:0] fl, logic iv, string tag);
        exp_t e;
        @(negedge clk);
        a_in = a; b_in = b; quiet_mode = q; inv_mask = m; pop_req = p;
        e.fl = fl; e.inv = iv; e.pop = p; e.tag = tag;
        sb_q.push_back(e);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
    endtask

    // monitor: results are due one cycle after start
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb_q.size() == 0) begin
                check("R9 unexpected done", 8'd1, 8'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, {5'b0, zf, pf, cf}, {5'b0, e.fl});
                check({e.tag, " inv_exc"}, {7'b0, inv_exc}, {7'b0, e.inv});
                check({e.tag, " pop R10"}, {7'b0, pop_out}, {7'b0, e.pop});
                check("R8 of_flag", {7'b0, of_flag}, 8'd0);
            end
        end else if (!rst) begin
            if (inv_exc || pop_out) check("R9 strobe without done", {6'b0, inv_exc, pop_out}, 8'd0);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        check("R11 reset state", {1'b0, done, zf, pf, cf, of_flag, inv_exc, pop_out}, 8'd0);

        do_cmp(P2, P1, 0, 1, 0, 3'b000, 0, "R1 gt");
        do_cmp(P1, P2, 0, 1, 0, 3'b001, 0, "R1 lt");
        do_cmp(P1, P1, 0, 1, 0, 3'b100, 0, "R1 eq");
        do_cmp(PZ, NZ, 0, 1, 0, 3'b100, 0, "R2 +0 vs -0");
        do_cmp(NZ, PZ, 1, 1, 0, 3'b100, 0, "R2 -0 vs +0");
        do_cmp(N2, N1, 0, 1, 0, 3'b001, 0, "R3 both neg lt");
        do_cmp(N1, N2, 0, 1, 0, 3'b000, 0, "R3 both neg gt");
        do_cmp(N1, P1, 0, 1, 0, 3'b001, 0, "R3 mixed sign");
        do_cmp(PINF, P2, 0, 1, 0, 3'b000, 0, "R1 inf gt");
        do_cmp(DN, PZ, 0, 1, 0, 3'b000, 0, "R1 denormal gt zero");
        do_cmp(NZ, DN, 0, 1, 0, 3'b001, 0, "R2 -0 lt denormal");
        do_cmp(QN, P1, 0, 1, 0, 3'b111, 1, "R4 signaling mode qnan");
        do_cmp(P1, SN, 0, 1, 0, 3'b111, 1, "R4 signaling mode snan");
        do_cmp(QN, P1, 1, 1, 0, 3'b111, 0, "R5 quiet qnan");
        do_cmp(P1, QN, 1, 0, 0, 3'b111, 0, "R5 quiet qnan unmasked");
        do_cmp(SN, P1, 1, 1, 0, 3'b111, 1, "R5 quiet snan");
        do_cmp(UN, P1, 1, 1, 0, 3'b111, 1, "R6 malformed quiet");
        do_cmp(P1, UN, 0, 1, 0, 3'b111, 1, "R6 malformed signaling");
        do_cmp(P2, P1, 0, 1, 0, 3'b000, 0, "R7 setup gt");
        do_cmp(QN, P1, 0, 0, 0, 3'b000, 1, "R7 unmasked hold gt");
        do_cmp(P1, P2, 0, 1, 0, 3'b001, 0, "R7 setup lt");
        do_cmp(SN, P2, 1, 0, 0, 3'b001, 1, "R7 unmasked hold lt");
        do_cmp(UN, UN, 1, 0, 1, 3'b001, 1, "R7 unmasked malformed pop");
        do_cmp(P1, P1, 0, 1, 1, 3'b100, 0, "R10 pop eq");

        // back-to-back starts: R9
        @(negedge clk);
        begin
            exp_t e1, e2;
            e1.fl = 3'b000; e1.inv = 0; e1.pop = 0; e1.tag = "R9 b2b first";
            e2.fl = 3'b001; e2.inv = 0; e2.pop = 1; e2.tag = "R9 b2b second";
            a_in = P2; b_in = P1; quiet_mode = 0; inv_mask = 1; pop_req = 0;
            sb_q.push_back(e1);
            start = 1'b1;
            @(negedge clk);
            a_in = P1; b_in = P2; pop_req = 1;
            sb_q.push_back(e2);
            @(negedge clk);
            start = 1'b0; pop_req = 0;
        end
        repeat (3) @(negedge clk);
        check("R9 queue drained", 8'(sb_q.size()), 8'd0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule